// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 32-bit processor. The core's issue stage hands it an operation on a valid/ready port. Each operation carries two source operands, the target accumulator, the operand format, a halfword mode with per-operand halfword selects, an add/subtract choice and a saturation enable. The unit forms the full product and adds it to, or subtracts it from, one of four 48-bit accumulators. The work runs through a fixed four-stage pipeline.

Software moves a result into a general register through a read port, which returns the contents and the sticky overflow flag of the selected accumulator. A write may still be in flight to the accumulator being read. In that case the read port holds off, and new issues are blocked until the read can complete, so a waiting read cannot be starved.

The arithmetic in the last stage always treats an accumulator as a signed 48-bit two's-complement value. Unsigned products enter that sum zero-extended.

Top module: `mac_unit`

## Requirements
- R1: After reset all four accumulators read 0, all overflow flags read 0, and both `iss_ready_o` and `rd_ready_o` are 1 while no read is waiting.
- R2: An operation accepted at rising edge E (`iss_valid_i` and `iss_ready_o` both 1) updates its accumulator at edge E+3. Between E and E+3 the read port returns the old contents.
- R3: With `iss_fmt_i` = 2'b01 (signed integer) the operands are two's-complement. The product is added to the accumulator when `iss_sub_i` = 0 and subtracted when `iss_sub_i` = 1.
- R4: With `iss_fmt_i` = 2'b00 (unsigned integer) the operands are zero-extended before multiplication. Encoding 2'b11 behaves as signed integer.
- R5: With `iss_half_i` = 1 each operand is a 16-bit value: bits [31:16] when its select bit (`iss_hi_a_i` or `iss_hi_b_i`) is 1, and bits [15:0] when it is 0. The value is sign-extended for the signed and fractional formats and zero-extended for unsigned.
- R6: With `iss_fmt_i` = 2'b10 (signed fractional) the operands are signed, and the product is shifted left by one bit before it is added or subtracted.
- R7: `iss_acc_i` selects one of four accumulators. An operation changes only the accumulator and flag it selects.
- R8: If the exact result falls outside the signed 48-bit range, the target's overflow flag is set and stays set until reset. With `iss_sat_i` = 0 the stored value is the low 48 bits of the exact result.
- R9: With `iss_sat_i` = 1, an overflowing result is stored as 48'h7FFF_FFFF_FFFF when positive and as 48'h8000_0000_0000 when negative. A result that does not overflow is stored unchanged.
- R10: `rd_ready_o` is 0 while any accepted operation targeting `rd_acc_i` has not yet written. When `rd_ready_o` is 1, `rd_data_o` and `rd_ovf_o` reflect every accepted operation on that accumulator.
- R11: `iss_ready_o` is 0 while `rd_valid_i` is 1 and `rd_ready_o` is 0.
- R12: Operations issued on consecutive cycles, including several to the same accumulator, all take effect, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_ready_o | output | 1 | Issue accepted when high together with valid |
| iss_op_a_i | input | 32 | Source operand A |
| iss_op_b_i | input | 32 | Source operand B |
| iss_acc_i | input | 2 | Target accumulator |
| iss_fmt_i | input | 2 | 00 unsigned, 01 signed, 10 signed fractional, 11 signed |
| iss_half_i | input | 1 | 16-bit operand mode |
| iss_hi_a_i | input | 1 | Upper halfword of A in 16-bit mode |
| iss_hi_b_i | input | 1 | Upper halfword of B in 16-bit mode |
| iss_sub_i | input | 1 | Subtract product instead of adding |
| iss_sat_i | input | 1 | Saturate on overflow |
| rd_valid_i | input | 1 | Accumulator read request |
| rd_acc_i | input | 2 | Accumulator to read |
| rd_ready_o | output | 1 | Read data is current |
| rd_data_o | output | 48 | Accumulator contents |
| rd_ovf_o | output | 1 | Sticky overflow flag of the read accumulator |

## Verification
The bench times a read against a single issue edge by edge. A design with one register too many or too few would show the new value a cycle early or late, or would raise `rd_ready_o` before the write lands. It probes the operand-extension corners: 0xFFFFFFFF unsigned against signed, the upper halfword 0x8000, and fractional products. A wrong extension or a missing shift changes the sum by a sign or by a factor of two. It drives products near 2^62 with and without saturation, so a design that drops the wrap, clamps to the wrong rail or clears the sticky flag on a later clean operation is caught. Back-to-back issues to one accumulator expose a final stage that reads a stale accumulator and loses an update.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [1:0] {
    FMT_UNS  = 2'd0,
    FMT_SGN  = 2'd1,
    FMT_FRAC = 2'd2,
    FMT_RSV  = 2'd3
  } mac_fmt_e;
endpackage

// File: rtl/mac_opsel.sv
`timescale 1ns/1ps
module mac_opsel #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0]   raw_i,
  input  logic              half_i,
  input  logic              hi_i,
  input  logic              uns_i,
  output logic signed [OP_W:0] ext_o
);
  localparam int HALF_W = OP_W / 2;

  logic [HALF_W-1:0] hw;
  logic              hw_sign;
  logic              full_sign;

  always_comb begin
    hw        = hi_i ? raw_i[OP_W-1 -: HALF_W] : raw_i[HALF_W-1:0];
    hw_sign   = hw[HALF_W-1] & ~uns_i;
    full_sign = raw_i[OP_W-1] & ~uns_i;
    if (half_i) ext_o = {{(OP_W+1-HALF_W){hw_sign}}, hw};
    else        ext_o = {full_sign, raw_i};
  end
endmodule

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
  parameter int OP_W = 32
) (
  input  logic signed [OP_W:0]     a_i,
  input  logic signed [OP_W:0]     b_i,
  output logic signed [2*OP_W+1:0] prod_o
);
  logic signed [2*OP_W+1:0] a_x, b_x;

  always_comb begin
    a_x    = $signed({{(OP_W+1){a_i[OP_W]}}, a_i});
    b_x    = $signed({{(OP_W+1){b_i[OP_W]}}, b_i});
    prod_o = a_x * b_x;
  end
endmodule

// File: rtl/mac_hazard.sv
`timescale 1ns/1ps
module mac_hazard #(
  parameter int N_STG = 3,
  parameter int SEL_W = 2
) (
  input  logic [N_STG-1:0]            v_i,
  input  logic [N_STG-1:0][SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0]            rsel_i,
  output logic                        pending_o
);
  logic [N_STG-1:0] hit;

  for (genvar g = 0; g < N_STG; g++) begin : g_cmp
    assign hit[g] = v_i[g] && (sel_i[g] == rsel_i);
  end

  assign pending_o = |hit;
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
module mac_accum #(
  parameter int ACC_W  = 48,
  parameter int N_ACC  = 4,
  parameter int TERM_W = 66
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [$clog2(N_ACC)-1:0]  wsel_i,
  input  logic signed [TERM_W-1:0]  term_i,
  input  logic                      sat_i,
  input  logic [$clog2(N_ACC)-1:0]  rsel_i,
  output logic [ACC_W-1:0]          rdata_o,
  output logic                      rovf_o
);
  localparam int SUM_W = TERM_W + 1;
  localparam int TOP_W = SUM_W - ACC_W + 1;
  localparam logic [ACC_W-1:0] POS_RAIL = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_RAIL = {1'b1, {(ACC_W-1){1'b0}}};

  logic [N_ACC-1:0][ACC_W-1:0] acc_q;
  logic [N_ACC-1:0]            ovf_q;

  logic signed [SUM_W-1:0] cur_ext, sum;
  logic [TOP_W-1:0]        top_bits;
  logic                    ovf_now;
  logic [ACC_W-1:0]        wval;

  always_comb begin
    cur_ext  = $signed({{(SUM_W-ACC_W){acc_q[wsel_i][ACC_W-1]}}, acc_q[wsel_i]});
    sum      = cur_ext + $signed({term_i[TERM_W-1], term_i});
    top_bits = sum[SUM_W-1:ACC_W-1];
    // exact result fits only if all bits above the sign agree with it
    ovf_now  = (|top_bits) && !(&top_bits);
    if (ovf_now && sat_i) wval = sum[SUM_W-1] ? NEG_RAIL : POS_RAIL;
    else                  wval = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= '0;
    end else if (we_i) begin
      acc_q[wsel_i] <= wval;
      if (ovf_now) ovf_q[wsel_i] <= 1'b1;
    end
  end

  assign rdata_o = acc_q[rsel_i];
  assign rovf_o  = ovf_q[rsel_i];

  // R7
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(acc_q));

  for (genvar i = 0; i < N_ACC; i++) begin : g_sticky
    // R8
    sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_q[i] |=> ovf_q[i]);
  end
endmodule

// File: rtl/mac_unit.sv
`timescale 1ns/1ps
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int ACC_W = 48,
  parameter int N_ACC = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     iss_valid_i,
  output logic                     iss_ready_o,
  input  logic [OP_W-1:0]          iss_op_a_i,
  input  logic [OP_W-1:0]          iss_op_b_i,
  input  logic [$clog2(N_ACC)-1:0] iss_acc_i,
  input  logic [1:0]               iss_fmt_i,
  input  logic                     iss_half_i,
  input  logic                     iss_hi_a_i,
  input  logic                     iss_hi_b_i,
  input  logic                     iss_sub_i,
  input  logic                     iss_sat_i,
  input  logic                     rd_valid_i,
  input  logic [$clog2(N_ACC)-1:0] rd_acc_i,
  output logic                     rd_ready_o,
  output logic [ACC_W-1:0]         rd_data_o,
  output logic                     rd_ovf_o
);
  localparam int SEL_W  = $clog2(N_ACC);
  localparam int PROD_W = 2*OP_W + 2;
  localparam int N_STG  = 3;

  logic iss_fire;
  logic pending;
  logic uns_in, frac_in;

  // stage 1: extended operands
  logic                    v1;
  logic signed [OP_W:0]    a1, b1;
  logic [SEL_W-1:0]        sel1;
  logic                    frac1, sub1, sat1;
  logic signed [OP_W:0]    a_ext, b_ext;
  // stage 2: product
  logic                    v2;
  logic signed [PROD_W-1:0] prod2, prod_c;
  logic [SEL_W-1:0]        sel2;
  logic                    frac2, sub2, sat2;
  // stage 3: aligned, signed term
  logic                    v3;
  logic signed [PROD_W-1:0] term3, term_c, aligned;
  logic [SEL_W-1:0]        sel3;
  logic                    sat3;

  assign uns_in  = (mac_fmt_e'(iss_fmt_i) == FMT_UNS);
  assign frac_in = (mac_fmt_e'(iss_fmt_i) == FMT_FRAC);

  mac_opsel #(.OP_W(OP_W)) u_sel_a (
    .raw_i(iss_op_a_i), .half_i(iss_half_i), .hi_i(iss_hi_a_i),
    .uns_i(uns_in), .ext_o(a_ext));

  mac_opsel #(.OP_W(OP_W)) u_sel_b (
    .raw_i(iss_op_b_i), .half_i(iss_half_i), .hi_i(iss_hi_b_i),
    .uns_i(uns_in), .ext_o(b_ext));

  mac_mult #(.OP_W(OP_W)) u_mult (.a_i(a1), .b_i(b1), .prod_o(prod_c));

  always_comb begin
    aligned = frac2 ? (prod2 <<< 1) : prod2;
    term_c  = sub2 ? -aligned : aligned;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; a1 <= '0; b1 <= '0; sel1 <= '0;
      frac1 <= 1'b0; sub1 <= 1'b0; sat1 <= 1'b0;
      v2 <= 1'b0; prod2 <= '0; sel2 <= '0;
      frac2 <= 1'b0; sub2 <= 1'b0; sat2 <= 1'b0;
      v3 <= 1'b0; term3 <= '0; sel3 <= '0; sat3 <= 1'b0;
    end else begin
      v1    <= iss_fire;
      a1    <= a_ext;
      b1    <= b_ext;
      sel1  <= iss_acc_i;
      frac1 <= frac_in;
      sub1  <= iss_sub_i;
      sat1  <= iss_sat_i;
      v2    <= v1;
      prod2 <= prod_c;
      sel2  <= sel1;
      frac2 <= frac1;
      sub2  <= sub1;
      sat2  <= sat1;
      v3    <= v2;
      term3 <= term_c;
      sel3  <= sel2;
      sat3  <= sat2;
    end
  end

  mac_hazard #(.N_STG(N_STG), .SEL_W(SEL_W)) u_haz (
    .v_i({v3, v2, v1}),
    .sel_i({sel3, sel2, sel1}),
    .rsel_i(rd_acc_i),
    .pending_o(pending));

  mac_accum #(.ACC_W(ACC_W), .N_ACC(N_ACC), .TERM_W(PROD_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(v3), .wsel_i(sel3), .term_i(term3), .sat_i(sat3),
    .rsel_i(rd_acc_i), .rdata_o(rd_data_o), .rovf_o(rd_ovf_o));

  assign rd_ready_o  = !pending;
  // block new work while a read waits so the read always drains
  assign iss_ready_o = !(rd_valid_i && pending);
  assign iss_fire    = iss_valid_i && iss_ready_o;

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v3 |-> $past(iss_fire, 3));

  // R10
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_fire |=> (rd_acc_i != $past(iss_acc_i)) || !rd_ready_o);
endmodule

// File: tb/mac_unit_tb_top.sv
`timescale 1ns/1ps
module mac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  acc_sel = '0;
  logic [1:0]  fmt = '0;
  logic        half = 1'b0, hi_a = 1'b0, hi_b = 1'b0, sub = 1'b0, sat = 1'b0;
  logic        rd_valid = 1'b0;
  logic [1:0]  rd_acc = '0;
  logic        rd_ready;
  logic [47:0] rd_data;
  logic        rd_ovf;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  logic [47:0] m_acc [4];
  logic        m_ovf [4];

  localparam logic signed [66:0] MAXV = 67'sd140737488355327;
  localparam logic signed [66:0] MINV = -67'sd140737488355328;

  always #2.5 clk = ~clk;

  mac_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_ready_o(iss_ready),
    .iss_op_a_i(op_a), .iss_op_b_i(op_b), .iss_acc_i(acc_sel),
    .iss_fmt_i(fmt), .iss_half_i(half), .iss_hi_a_i(hi_a), .iss_hi_b_i(hi_b),
    .iss_sub_i(sub), .iss_sat_i(sat),
    .rd_valid_i(rd_valid), .rd_acc_i(rd_acc), .rd_ready_o(rd_ready),
    .rd_data_o(rd_data), .rd_ovf_o(rd_ovf));

  task automatic chk48(string tag, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic signed [32:0] f_ext(logic [31:0] v, logic h, logic hi, logic uns);
    logic [15:0] w;
    w = hi ? v[31:16] : v[15:0];
    if (h) return uns ? $signed({17'd0, w}) : $signed({{17{w[15]}}, w});
    return uns ? $signed({1'b0, v}) : $signed({v[31], v});
  endfunction

  task automatic model_op(logic [1:0] ac, logic [31:0] a, logic [31:0] b, logic [1:0] f,
                          logic h, logic ha, logic hb, logic sb, logic st);
    logic signed [32:0] ea, eb;
    logic signed [65:0] p;
    logic signed [66:0] s;
    logic               ov;
    ea = f_ext(a, h, ha, f == 2'b00);
    eb = f_ext(b, h, hb, f == 2'b00);
    p  = $signed({{33{ea[32]}}, ea}) * $signed({{33{eb[32]}}, eb});
    if (f == 2'b10) p = p <<< 1;
    if (sb) p = -p;
    s  = $signed({p[65], p}) + $signed({{19{m_acc[ac][47]}}, m_acc[ac]});
    ov = (s > MAXV) || (s < MINV);
    if (ov) m_ovf[ac] = 1'b1;
    if (ov && st) m_acc[ac] = (s < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
    else          m_acc[ac] = s[47:0];
  endtask

  task automatic drive_op(logic [1:0] ac, logic [31:0] a, logic [31:0] b, logic [1:0] f,
                          logic h, logic ha, logic hb, logic sb, logic st);
    @(negedge clk);
    acc_sel = ac; op_a = a; op_b = b; fmt = f;
    half = h; hi_a = ha; hi_b = hb; sub = sb; sat = st;
    iss_valid = 1'b1;
    model_op(ac, a, b, f, h, ha, hb, sb, st);
  endtask

  task automatic idle_settle();
    @(negedge clk);
    iss_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd_valid = 1'b1;
      rd_acc   = 2'(i);
      #1;
      chk1({tag, " ready"}, rd_ready, 1'b1);
      chk48({tag, " data"}, rd_data, m_acc[i]);
      chk1({tag, " ovf"}, rd_ovf, m_ovf[i]);
    end
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rd_valid = 1'b0;
    iss_valid = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m_acc[i] = '0;
      m_ovf[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk1("R1 iss_ready", iss_ready, 1'b1);
    chk1("R1 rd_ready", rd_ready, 1'b1);
    check_all("R1");
  endtask

  task automatic t_signed();
    do_reset();
    drive_op(2'd0, 32'hFFFF_FFFD, 32'd7, 2'b01, 0, 0, 0, 0, 0);
    drive_op(2'd0, 32'd5, 32'hFFFF_FFFC, 2'b01, 0, 0, 0, 1, 0);
    drive_op(2'd0, 32'h8000_0000, 32'd3, 2'b11, 0, 0, 0, 0, 0);
    idle_settle();
    check_all("R3");
  endtask

  task automatic t_unsigned();
    do_reset();
    drive_op(2'd1, 32'hFFFF_FFFF, 32'd2, 2'b00, 0, 0, 0, 0, 0);
    drive_op(2'd2, 32'hFFFF_FFFF, 32'd2, 2'b11, 0, 0, 0, 0, 0);
    idle_settle();
    check_all("R4");
  endtask

  task automatic t_half();
    do_reset();
    drive_op(2'd2, 32'h8000_0003, 32'h0005_FFFF, 2'b01, 1, 0, 1, 0, 0);
    drive_op(2'd2, 32'h8000_0003, 32'h0005_FFFF, 2'b01, 1, 1, 0, 0, 0);
    drive_op(2'd3, 32'h8000_0003, 32'h0005_FFFF, 2'b00, 1, 1, 0, 0, 0);
    idle_settle();
    check_all("R5");
  endtask

  task automatic t_frac();
    do_reset();
    drive_op(2'd3, 32'h0000_4000, 32'h4000_0000, 2'b10, 1, 0, 1, 0, 0);
    drive_op(2'd1, 32'h0001_0000, 32'hFFFF_FFFD, 2'b10, 0, 0, 0, 0, 0);
    drive_op(2'd1, 32'h0000_0010, 32'h0000_0010, 2'b10, 0, 0, 0, 1, 0);
    idle_settle();
    check_all("R6");
  endtask

  task automatic t_indep();
    do_reset();
    drive_op(2'd2, 32'd1000, 32'd1000, 2'b01, 0, 0, 0, 0, 0);
    drive_op(2'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b01, 0, 0, 0, 0, 0);
    idle_settle();
    check_all("R7");
  endtask

  task automatic t_latency();
    do_reset();
    drive_op(2'd1, 32'd6, 32'd7, 2'b01, 0, 0, 0, 0, 0);
    @(negedge clk);          // just past the accepting edge
    iss_valid = 1'b0;
    rd_valid  = 1'b1;
    rd_acc    = 2'd0;
    #1;
    chk1("R10 other acc ready", rd_ready, 1'b1);
    rd_acc = 2'd1;
    #1;
    chk1("R10 stall", rd_ready, 1'b0);
    chk1("R11 issue blocked", iss_ready, 1'b0);
    chk48("R2 old value", rd_data, 48'd0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      #1;
      chk1("R10 stall", rd_ready, 1'b0);
      chk48("R2 old value", rd_data, 48'd0);
    end
    @(negedge clk);
    #1;
    chk1("R2 ready after write", rd_ready, 1'b1);
    chk1("R11 issue free", iss_ready, 1'b1);
    chk48("R2 new value", rd_data, m_acc[1]);
    rd_valid = 1'b0;
  endtask

  task automatic t_ovf();
    do_reset();
    drive_op(2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b01, 0, 0, 0, 0, 0);
    idle_settle();
    check_all("R8");
    drive_op(2'd0, 32'd1, 32'd1, 2'b01, 0, 0, 0, 0, 0);
    idle_settle();
    check_all("R8 sticky");
  endtask

  task automatic t_sat();
    do_reset();
    drive_op(2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b01, 0, 0, 0, 0, 1);
    drive_op(2'd2, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 2'b01, 0, 0, 0, 1, 1);
    drive_op(2'd3, 32'd3, 32'd4, 2'b01, 0, 0, 0, 0, 1);
    idle_settle();
    chk48("R9 pos rail model", m_acc[1], 48'h7FFF_FFFF_FFFF);
    check_all("R9");
  endtask

  task automatic t_b2b();
    do_reset();
    drive_op(2'd1, 32'd11, 32'd13, 2'b01, 0, 0, 0, 0, 0);
    drive_op(2'd1, 32'd17, 32'd19, 2'b01, 0, 0, 0, 0, 0);
    drive_op(2'd1, 32'd23, 32'd29, 2'b01, 0, 0, 0, 1, 0);
    drive_op(2'd2, 32'd31, 32'd37, 2'b00, 0, 0, 0, 0, 0);
    drive_op(2'd1, 32'hFFFF_FFFF, 32'd41, 2'b01, 0, 0, 0, 0, 0);
    idle_settle();
    check_all("R12");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_signed();
    t_unsigned();
    t_half();
    t_frac();
    t_indep();
    t_ovf();
    t_sat();
    t_b2b();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule